// File: doc/BRIEF.md
# System SRAM Controller Register Bank

This block is the register bank of a system SRAM controller. It sits on a simple 32-bit bus slave port with address, write data, byte enables, write enable and read enable, and it decodes a 1 KiB window. The window holds three registers: a configuration word that drives the controller's remapping, a scratch word that boot software uses as an entry point, and an identification word. The identification word stays hidden behind a lock. Software first sets a single unlock bit in that word, which is the only writable bit in it. After that, the fixed version code can be read.

Every access must be a full, word-aligned 32-bit transfer to one of the three mapped offsets. Any other access changes no state and returns zero on a read. It also raises a one-cycle error pulse that the system can route to a bus error response. Writes take effect on the clock edge that samples the write enable. Read data is registered and appears one cycle after the read enable, and it holds between reads.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the configuration word is 32'h0000_1300, the entry word and the unlock bit are 0, and busRdata and busErr are 0.
- R2: The configuration word (byte offset 0x04) and the entry word (byte offset 0xBC) accept all 32 written bits. A read returns the stored value.
- R3: A write to the identification word (byte offset 0x24) stores only bit 15, the unlock bit. All other written bits are discarded.
- R4: While the unlock bit is 0, a read of offset 0x24 returns 32'h0.
- R5: While the unlock bit is 1, a read of offset 0x24 returns the version code in bits 31:16 and a 1 in bit 15, with bits 14:0 reading 0. With the default code 16'h1701 this is 32'h1701_8000.
- R6: A read of any other word offset in the 1 KiB window returns 0. A write to it changes no register. Either access raises busErr.
- R7: An access whose address bits 1:0 are not 00, or whose busByteEn is not 4'b1111, is ignored and raises busErr. Ignored here means no register changes and a read returns 0.
- R8: busErr is high for exactly the one cycle after a faulty access and low after a valid access or an idle cycle.
- R9: busRdata is registered. It takes the read value in the cycle after busRdEn and holds it unchanged while busRdEn is low.
- R10: A write takes effect on the clock edge where busWrEn is sampled high. A read issued on the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Byte address within the 1 KiB window |
| busWdata | input | 32 | Write data |
| busByteEn | input | 4 | Byte enables; only 4'b1111 is a valid access |
| busWrEn | input | 1 | Write request, sampled on the rising edge |
| busRdEn | input | 1 | Read request, sampled on the rising edge |
| busRdata | output | 32 | Registered read data, valid one cycle after busRdEn |
| busErr | output | 1 | One-cycle pulse after a faulty or unmapped access |

## Verification
The bench writes a distinct pattern to every one of the 256 word offsets and then reads every offset back. This catches a decoder that aliases an unmapped offset onto a register, and a decoder that ignores high address bits; either would corrupt a mapped word or return nonzero data. It sweeps every partial byte-enable pattern and every misaligned address against a live register. A design that merged partial writes or dropped the low address bits would change the word or miss the error pulse. It also writes the identification word with all ones and with all bits but bit 15 set, and reads it both locked and unlocked. A bank that stored the whole word, or that ignored the lock, would return the wrong value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int NUM_REGS = 3;

  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_VER   = 2'd1,
    SEL_ENTRY = 2'd2
  } regSel_e;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic [NUM_REGS-1:0] rdSel;
    logic                rdLoad;
  } ctlStrobes_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BE_W = 4,
  parameter logic [ADDR_W-1:0] CFG_OFS = 10'h004,
  parameter logic [ADDR_W-1:0] VER_OFS = 10'h024,
  parameter logic [ADDR_W-1:0] ENTRY_OFS = 10'h0BC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busByteEn,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctlStrobes_t       strobes,
  output logic              busErr
);

  localparam int LSB_W = $clog2(BE_W);
  localparam logic [NUM_REGS-1:0][ADDR_W-1:0] OFS_TABLE = {ENTRY_OFS, VER_OFS, CFG_OFS};

  logic [NUM_REGS-1:0] hitVec;
  logic aligned;
  logic fullWord;
  logic legal;
  logic anyAccess;
  logic badAccess;

  assign aligned   = (busAddr[LSB_W-1:0] == '0);
  assign fullWord  = &busByteEn;
  assign anyAccess = busWrEn | busRdEn;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hitVec[i] = (busAddr[ADDR_W-1:LSB_W] == OFS_TABLE[i][ADDR_W-1:LSB_W]);
  end

  assign legal     = aligned & fullWord & (|hitVec);
  assign badAccess = anyAccess & ~legal;

  always_comb begin
    strobes.wrSel  = (busWrEn & legal) ? hitVec : '0;
    strobes.rdSel  = (busRdEn & legal) ? hitVec : '0;
    strobes.rdLoad = busRdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= badAccess;
  end

  // R7: partial or misaligned access always flags an error next cycle
  a_r7_bad_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (anyAccess && (busByteEn != {BE_W{1'b1}} || busAddr[LSB_W-1:0] != '0)) |=> busErr);

  // R7: partial or misaligned access never selects a register
  a_r7_no_select: assert property (@(posedge clk) disable iff (!rstN)
    (busByteEn != {BE_W{1'b1}}) |-> (strobes.wrSel == '0 && strobes.rdSel == '0));

  // R8: idle cycle leaves no error behind
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !anyAccess |=> !busErr);

  // R6: at most one register selected per direction
  a_r6_single_sel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrSel) && $onehot0(strobes.rdSel));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [15:0] VER_CODE = 16'h1701,
  parameter logic [DATA_W-1:0] CFG_RST = 32'h0000_1300,
  parameter int UNLOCK_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  localparam int VER_SHIFT = UNLOCK_BIT + 1;

  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] entryReg;
  logic              unlockBit;
  logic [DATA_W-1:0] verView;
  logic [DATA_W-1:0] readWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= CFG_RST;
      entryReg  <= '0;
      unlockBit <= 1'b0;
    end else begin
      if (strobes.wrSel[SEL_CFG])   cfgReg    <= busWdata;
      if (strobes.wrSel[SEL_ENTRY]) entryReg  <= busWdata;
      if (strobes.wrSel[SEL_VER])   unlockBit <= busWdata[UNLOCK_BIT];
    end
  end

  always_comb begin
    verView = '0;
    if (unlockBit) begin
      verView[UNLOCK_BIT] = 1'b1;
      verView[VER_SHIFT +: 16] = VER_CODE;
    end
  end

  always_comb begin
    readWord = '0;
    if (strobes.rdSel[SEL_CFG])   readWord = readWord | cfgReg;
    if (strobes.rdSel[SEL_VER])   readWord = readWord | verView;
    if (strobes.rdSel[SEL_ENTRY]) readWord = readWord | entryReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               busRdata <= '0;
    else if (strobes.rdLoad) busRdata <= readWord;
  end

  // R2: full-word write to the configuration register lands intact
  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSel[SEL_CFG] |=> cfgReg == $past(busWdata));

  // R3: only the unlock bit of the written word is kept
  a_r3_ver_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSel[SEL_VER] |=> unlockBit == $past(busWdata[UNLOCK_BIT]));

  // R4: locked identification read returns zero
  a_r4_locked_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel[SEL_VER] && !unlockBit) |=> busRdata == '0);

  // R5: unlocked identification read shows the code
  a_r5_unlocked_code: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel[SEL_VER] && unlockBit) |=>
      (busRdata[VER_SHIFT +: 16] == VER_CODE && busRdata[UNLOCK_BIT:0] == {1'b1, {UNLOCK_BIT{1'b0}}}));

  // R9: read data holds between reads
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdLoad |=> $stable(busRdata));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter logic [15:0] VER_CODE = 16'h1701,
  parameter logic [DATA_W-1:0] CFG_RST = 32'h0000_1300,
  parameter logic [ADDR_W-1:0] CFG_OFS = 10'h004,
  parameter logic [ADDR_W-1:0] VER_OFS = 10'h024,
  parameter logic [ADDR_W-1:0] ENTRY_OFS = 10'h0BC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W/8-1:0] busByteEn,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr
);

  localparam int BE_W = DATA_W / 8;

  ctlStrobes_t strobes;

  sysctl_decode #(
    .ADDR_W(ADDR_W), .BE_W(BE_W),
    .CFG_OFS(CFG_OFS), .VER_OFS(VER_OFS), .ENTRY_OFS(ENTRY_OFS)
  ) u_decode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .strobes(strobes), .busErr(busErr)
  );

  sysctl_regs #(
    .DATA_W(DATA_W), .VER_CODE(VER_CODE), .CFG_RST(CFG_RST), .UNLOCK_BIT(15)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata), .busRdata(busRdata)
  );

endmodule

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busByteEn = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdata;
  logic        busErr;

  int nChecks = 0;
  int nFails = 0;

  // model state, from the requirements
  logic [31:0] mCfg = 32'h0000_1300;
  logic [31:0] mEntry = '0;
  logic        mUnlock = 1'b0;

  sysctl_regbank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busByteEn(busByteEn), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busRdata(busRdata), .busErr(busErr)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic isMapped(input logic [9:0] a);
    return (a == 10'h004) || (a == 10'h024) || (a == 10'h0BC);
  endfunction

  function automatic logic [31:0] expRead(input logic [9:0] a);
    if (a == 10'h004) return mCfg;
    if (a == 10'h0BC) return mEntry;
    if (a == 10'h024) return mUnlock ? 32'h1701_8000 : 32'h0;
    return 32'h0;
  endfunction

  task automatic doWrite(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
    logic ok;
    @(negedge clk);
    busAddr = a; busWdata = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    ok = isMapped(a) && be == 4'hF;
    if (ok) begin
      if (a == 10'h004) mCfg = d;
      if (a == 10'h0BC) mEntry = d;
      if (a == 10'h024) mUnlock = d[15];
    end
    check({tag, " err"}, {31'b0, busErr}, {31'b0, !ok});
  endtask

  task automatic doRead(input logic [9:0] a, input logic [3:0] be, input string tag);
    logic ok;
    @(negedge clk);
    busAddr = a; busByteEn = be; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    ok = isMapped(a) && be == 4'hF;
    check({tag, " data"}, busRdata, ok ? expRead(a) : 32'h0);
    check({tag, " err"}, {31'b0, busErr}, {31'b0, !ok});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 rdata", busRdata, 32'h0);
    check("R1 err", {31'b0, busErr}, 32'h0);
    doRead(10'h004, 4'hF, "R1 cfg");
    doRead(10'h0BC, 4'hF, "R1 entry");
    doRead(10'h024, 4'hF, "R1 ver locked");

    // R3 / R4: writes without bit 15 keep it locked
    doWrite(10'h024, 32'hFFFF_7FFF, 4'hF, "R3 ver");
    doRead(10'h024, 4'hF, "R4 still locked");
    // R5: unlock
    doWrite(10'h024, 32'h0000_8000, 4'hF, "R3 unlock");
    doRead(10'h024, 4'hF, "R5 unlocked");
    doWrite(10'h024, 32'hFFFF_FFFF, 4'hF, "R3 all ones");
    doRead(10'h024, 4'hF, "R5 all ones");
    doWrite(10'h024, 32'h0000_0000, 4'hF, "R3 relock");
    doRead(10'h024, 4'hF, "R4 relocked");

    // R2 / R10: full-word read/write patterns, read right after write
    for (int k = 0; k < 8; k++) begin
      doWrite(10'h004, 32'hA5A5_0000 ^ (32'h1 << (k * 4)) ^ {k[7:0], 24'h0}, 4'hF, "R10 cfg");
      doRead(10'h004, 4'hF, "R2 cfg");
      doWrite(10'h0BC, ~(32'h0F0F_0000 + k * 32'h0101_0101), 4'hF, "R10 entry");
      doRead(10'h0BC, 4'hF, "R2 entry");
    end

    // R7: every partial byte-enable pattern on live registers
    for (int b = 0; b < 15; b++) begin
      doWrite(10'h004, 32'hDEAD_0000 | b, b[3:0], "R7 be cfg");
      doWrite(10'h024, 32'h0000_8000, b[3:0], "R7 be ver");
      doRead(10'h0BC, b[3:0], "R7 be read");
      doRead(10'h004, 4'hF, "R7 cfg unchanged");
      doRead(10'h024, 4'hF, "R7 ver unchanged");
    end
    // R7: misaligned addresses near each register
    for (int o = 1; o < 4; o++) begin
      doWrite(10'h004 + o[9:0], 32'h1234_5678, 4'hF, "R7 mis cfg");
      doWrite(10'h0BC + o[9:0], 32'h8765_4321, 4'hF, "R7 mis entry");
      doRead(10'h024 + o[9:0], 4'hF, "R7 mis read");
      doRead(10'h004, 4'hF, "R7 cfg kept");
      doRead(10'h0BC, 4'hF, "R7 entry kept");
    end

    // R6: write sweep over every word offset, then read sweep
    for (int w = 0; w < 256; w++) begin
      doWrite({w[7:0], 2'b00}, {w[7:0], ~w[7:0], w[7:0], 8'h80} | 32'h0000_8000, 4'hF, "R6 wsweep");
    end
    for (int w = 0; w < 256; w++) begin
      doRead({w[7:0], 2'b00}, 4'hF, "R6 rsweep");
    end

    // R8: error pulse lasts one cycle
    doRead(10'h3FC, 4'hF, "R8 bad");
    @(negedge clk);
    check("R8 pulse ends", {31'b0, busErr}, 32'h0);

    // R9: data holds across idle cycles
    doRead(10'h004, 4'hF, "R9 load");
    held = busRdata;
    repeat (5) @(negedge clk);
    check("R9 hold", busRdata, held);
    doWrite(10'h004, ~held, 4'hF, "R9 write no read");
    check("R9 hold after write", busRdata, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule